// File: doc/BRIEF.md
# Colour Matrix Coefficient Converter

This block takes the nine coefficients of a 3x3 colour-transform matrix, each in 64-bit sign-magnitude fixed point (a sign flag at bit 63, 31 integer bits at 62:32 and 32 fraction bits at 31:0). It turns each one into a 15-bit two's-complement value with 3 integer bits and 12 fraction bits, which is the form a colour-adjust datapath holds. The fraction is truncated, not rounded. Each converted value is range-checked.

Coefficients arrive one per valid cycle, in row-major order, and a last marker goes with the final one. Idle cycles between coefficients are allowed. One cycle after the last coefficient is sampled, the block pulses a result strobe with an ok flag for the whole matrix. It updates its nine output registers together, and only when the matrix is accepted. A rejected matrix leaves the registers holding the previously accepted one.

Top module: `ctm_coef_unit`

## Requirements
- R1: For a coefficient with bit 63 clear, the converted value equals input bits 34:20 (the magnitude shifted right by 20 and kept to 15 bits).
- R2: For a coefficient with bit 63 set, the converted value is the 15-bit two's-complement negation of input bits 34:20 (invert, then add one, modulo 2^15).
- R3: A coefficient is invalid when bit 63 differs from bit 14 of its converted value. So a positive input with bits 34:20 at 0x4000 or above is invalid, and a negative input with bits 34:20 equal to zero is invalid.
- R4: A negative input with bits 34:20 from 0x0001 to 0x4000 is valid. Truncated magnitude 0x2000 gives 0x6000, and 0x4000 gives 0x4000.
- R5: Input bits 62:35 and 19:0 affect neither the converted value nor its validity.
- R6: res_vld_o is high for exactly the one cycle after a cycle in which coef_vld_i and coef_last_i are both high, and low at all other times; res_ok_o is meaningful only then.
- R7: A matrix containing any invalid coefficient gives res_ok_o = 0 and leaves coef_o unchanged.
- R8: On an accepted matrix, slot k of coef_o (bits 15k+14 down to 15k) holds the k-th valid coefficient of that matrix, counting from 0. All slots update in the same cycle as the strobe. Cycles with coef_vld_i low are ignored.
- R9: A matrix whose last marker comes with any coefficient other than the ninth (fewer or more than nine entries) is rejected, and coef_o is unchanged.
- R10: After reset, res_vld_o and res_ok_o are 0 and coef_o is 0. After every last marker, the next valid coefficient counts as entry 0 of a new matrix, and no earlier error carries over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_vld_i | input | 1 | Coefficient present this cycle |
| coef_last_i | input | 1 | Marks the final coefficient of a matrix |
| coef_raw_i | input | 64 | Sign-magnitude S31.32 coefficient |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_ok_o | output | 1 | Matrix accepted, valid with res_vld_o |
| coef_o | output | 135 | Nine Q3.12 slots, slot k at bits 15k+14:15k |

## Verification
Matrices of plain positive values carrying fraction noise show that truncation keeps bits 34:20 and that entries land in the right slots. Negative matrices separate correct negation from sign-magnitude passthrough, and the 0x2000 and 0x4000 magnitudes show that the range check runs after negation rather than before it. Single faulty entries are placed at different positions: positive 0x4000, negative zero, an eight-entry matrix and a ten-entry matrix. Each must give a reject with coef_o held. Inputs with garbage above bit 34, and matrices with idle gaps, show that the masking and the valid qualification both work.

// File: rtl/ctm_conv_pkg.sv
package ctm_conv_pkg;
  localparam int unsigned CTM_IN_W  = 64;
  localparam int unsigned CTM_OUT_W = 15;
  localparam int unsigned CTM_DROP  = 20;
  localparam int unsigned CTM_N     = 9;
endpackage

// File: rtl/ctm_coef_conv.sv
module ctm_coef_conv #(
  parameter int unsigned IN_W  = 64,
  parameter int unsigned OUT_W = 15,
  parameter int unsigned DROP  = 20
) (
  input  logic [IN_W-1:0]  raw_i,
  output logic             sign_o,
  output logic [OUT_W-1:0] mag_o,
  output logic [OUT_W-1:0] val_o,
  output logic             bad_o
);
  localparam int unsigned HI_LSB = DROP + OUT_W;

  logic unused_bits;
  assign unused_bits = ^{raw_i[IN_W-2:HI_LSB], raw_i[DROP-1:0]};

  assign sign_o = raw_i[IN_W-1];
  // window select == shift by DROP then mask to OUT_W bits
  assign mag_o  = raw_i[DROP +: OUT_W];
  assign val_o  = sign_o ? (~mag_o + OUT_W'(1)) : mag_o;
  // range check after negation so the most negative code survives
  assign bad_o  = sign_o ^ val_o[OUT_W-1];
endmodule

// File: rtl/ctm_coef_track.sv
module ctm_coef_track #(
  parameter int unsigned N     = 9,
  parameter int unsigned OUT_W = 15,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic                      last_i,
  input  logic                      sign_i,
  input  logic [OUT_W-1:0]          mag_i,
  input  logic [OUT_W-1:0]          val_i,
  input  logic                      bad_i,
  output logic [N-1:0][OUT_W-1:0]   shadow_o,
  output logic [CNT_W-1:0]          idx_o,
  output logic                      commit_o,
  output logic                      res_vld_o,
  output logic                      res_ok_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(N);
  localparam logic [OUT_W-1:0] NEG_MAX  = OUT_W'(1) << (OUT_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic             in_range;
  logic             ok_now;
  logic             end_now;

  assign in_range = cnt_q < FULL;
  assign end_now  = vld_i && last_i;
  assign ok_now   = !err_q && !bad_i && (cnt_q == LAST_IDX);
  assign commit_o = end_now && ok_now;
  assign idx_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      err_q     <= 1'b0;
      res_vld_o <= 1'b0;
      res_ok_o  <= 1'b0;
    end else begin
      res_vld_o <= end_now;
      res_ok_o  <= commit_o;
      if (end_now) begin
        cnt_q <= '0;
        err_q <= 1'b0;
      end else if (vld_i) begin
        if (in_range) cnt_q <= cnt_q + CNT_W'(1);
        err_q <= err_q | bad_i | !in_range;
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shadow_o[k] <= '0;
      else if (vld_i && !last_i && cnt_q == CNT_W'(k)) shadow_o[k] <= val_i;
    end
  end

  p_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_now |=> res_vld_o);
  p_strobe_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_now |=> !res_vld_o);
  p_ok_only_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ok_o |-> res_vld_o);
  p_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_now && cnt_q != LAST_IDX) |=> !res_ok_o);
  p_bad_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_now && bad_i) |=> !res_ok_o);
  p_bad_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !last_i && bad_i) |=> err_q);
  p_pos_big_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !sign_i && mag_i[OUT_W-1]) |-> bad_i);
  p_neg_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sign_i && mag_i == '0) |-> bad_i);
  p_neg_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sign_i && mag_i != '0 && mag_i <= (NEG_MAX >> 1)) |-> !bad_i);
  p_fresh_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_now |=> (cnt_q == '0 && !err_q));
endmodule

// File: rtl/ctm_coef_bank.sv
module ctm_coef_bank #(
  parameter int unsigned N     = 9,
  parameter int unsigned OUT_W = 15,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [CNT_W-1:0]        idx_i,
  input  logic [OUT_W-1:0]        val_i,
  input  logic [N-1:0][OUT_W-1:0] shadow_i,
  output logic [N*OUT_W-1:0]      coef_o
);
  for (genvar k = 0; k < N; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) coef_o[k*OUT_W +: OUT_W] <= '0;
      else if (commit_i)
        coef_o[k*OUT_W +: OUT_W] <= (idx_i == CNT_W'(k)) ? val_i : shadow_i[k];
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(coef_o));
  p_last_slot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> coef_o[(N-1)*OUT_W +: OUT_W] == $past(val_i));
endmodule

// File: rtl/ctm_coef_unit.sv
module ctm_coef_unit
  import ctm_conv_pkg::*;
#(
  parameter int unsigned IN_W  = CTM_IN_W,
  parameter int unsigned OUT_W = CTM_OUT_W,
  parameter int unsigned DROP  = CTM_DROP,
  parameter int unsigned N     = CTM_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               coef_vld_i,
  input  logic               coef_last_i,
  input  logic [IN_W-1:0]    coef_raw_i,
  output logic               res_vld_o,
  output logic               res_ok_o,
  output logic [N*OUT_W-1:0] coef_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  logic                    sign;
  logic [OUT_W-1:0]        mag;
  logic [OUT_W-1:0]        val;
  logic                    bad;
  logic [N-1:0][OUT_W-1:0] shadow;
  logic [CNT_W-1:0]        idx;
  logic                    commit;

  ctm_coef_conv #(.IN_W(IN_W), .OUT_W(OUT_W), .DROP(DROP)) u_conv (
    .raw_i (coef_raw_i),
    .sign_o(sign),
    .mag_o (mag),
    .val_o (val),
    .bad_o (bad)
  );

  ctm_coef_track #(.N(N), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (coef_vld_i),
    .last_i   (coef_last_i),
    .sign_i   (sign),
    .mag_i    (mag),
    .val_i    (val),
    .bad_i    (bad),
    .shadow_o (shadow),
    .idx_o    (idx),
    .commit_o (commit),
    .res_vld_o(res_vld_o),
    .res_ok_o (res_ok_o)
  );

  ctm_coef_bank #(.N(N), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .idx_i   (idx),
    .val_i   (val),
    .shadow_i(shadow),
    .coef_o  (coef_o)
  );
endmodule

// File: tb/tb_ctm_coef_unit.sv
`timescale 1ns/1ps
module tb_ctm_coef_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic         last = 1'b0;
  logic [63:0]  raw = '0;
  logic         res_vld, res_ok;
  logic [134:0] coef;

  int total = 0;
  int bad_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctm_coef_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .coef_vld_i(vld), .coef_last_i(last),
    .coef_raw_i(raw), .res_vld_o(res_vld), .res_ok_o(res_ok), .coef_o(coef)
  );

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad_cnt++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_conv(input logic [63:0] r, output logic [14:0] v, output bit b);
    longint unsigned m;
    m = ((r & 64'h7fff_ffff_ffff_ffff) >> 20) % 32768;
    if (r[63]) v = 15'((32768 - m) % 32768);
    else       v = 15'(m);
    b = (r[63] != v[14]);
  endfunction

  function automatic logic [63:0] pos(input int q);
    return 64'(q) << 20;
  endfunction
  function automatic logic [63:0] neg(input int q);
    return {1'b1, 63'(64'(q) << 20)};
  endfunction

  // reference model
  int           m_cnt;
  bit           m_err;
  logic [14:0]  m_sh [9];
  logic [134:0] m_coef;
  bit           m_vld, m_ok;
  logic [14:0]  t_v;
  bit           t_b, t_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_err <= 0; m_coef <= '0; m_vld <= 0; m_ok <= 0;
      for (int k = 0; k < 9; k++) m_sh[k] <= '0;
    end else begin
      m_vld <= vld && last;
      m_ok  <= 1'b0;
      if (vld) begin
        ref_conv(raw, t_v, t_b);
        if (last) begin
          t_ok = !m_err && !t_b && (m_cnt == 8);
          m_ok <= t_ok;
          if (t_ok) begin
            for (int k = 0; k < 8; k++) m_coef[k*15 +: 15] <= m_sh[k];
            m_coef[120 +: 15] <= t_v;
          end
          m_cnt <= 0; m_err <= 0;
        end else begin
          if (m_cnt < 9) begin m_sh[m_cnt] <= t_v; m_cnt <= m_cnt + 1; end
          if (m_cnt >= 9 || t_b) m_err <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(res_vld == m_vld, "R6 model strobe", longint'(res_vld), longint'(m_vld));
      check(res_ok == m_ok, "R7 model ok", longint'(res_ok), longint'(m_ok));
      check(coef == m_coef, "R8 model coef", longint'(coef[63:0]), longint'(m_coef[63:0]));
    end
  end

  logic [63:0] mat [0:11];
  bit seen_vld, seen_ok;

  task automatic run(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1; raw = mat[i]; last = (i == n - 1);
      if (gaps && i < n - 1) begin
        @(negedge clk); vld = 0; raw = 64'hdead_beef_dead_beef; last = 1;
        @(negedge clk); vld = 0; last = 0;
      end
    end
    @(negedge clk);
    vld = 0; last = 0; raw = '0;
    seen_vld = res_vld; seen_ok = res_ok;
    check(seen_vld == 1, "R6 strobe after last", longint'(seen_vld), 1);
    @(negedge clk);
    check(res_vld == 0, "R6 strobe single cycle", longint'(res_vld), 0);
  endtask

  function automatic logic [14:0] slot(input int k);
    return coef[k*15 +: 15];
  endfunction

  logic [134:0] held;

  initial begin
    repeat (3) @(negedge clk);
    check(res_vld == 0 && res_ok == 0, "R10 reset strobe", longint'(res_vld), 0);
    check(coef == '0, "R10 reset coef", longint'(coef[63:0]), 0);
    rst_n = 1;

    // positive with fraction noise
    for (int k = 0; k < 9; k++) mat[k] = pos(256 * (k + 1)) | 64'h0_abcde;
    run(9, 0);
    check(seen_ok == 1, "R1 positive matrix ok", longint'(seen_ok), 1);
    for (int k = 0; k < 9; k++)
      check(slot(k) == 15'(256 * (k + 1)), "R1 R8 slot value", longint'(slot(k)), 256 * (k + 1));

    // negatives incl. 0x2000 and 0x4000
    mat[0] = neg(14'h2000); mat[1] = neg(15'h4000); mat[2] = neg(1) | 64'hf_ffff;
    for (int k = 3; k < 9; k++) mat[k] = pos(15'h3fff);
    run(9, 0);
    check(seen_ok == 1, "R4 negative range ok", longint'(seen_ok), 1);
    check(slot(0) == 15'h6000, "R4 neg 0x2000", longint'(slot(0)), 15'h6000);
    check(slot(1) == 15'h4000, "R4 neg 0x4000", longint'(slot(1)), 15'h4000);
    check(slot(2) == 15'h7fff, "R2 neg one", longint'(slot(2)), 15'h7fff);
    check(slot(8) == 15'h3fff, "R1 max positive", longint'(slot(8)), 15'h3fff);
    held = coef;

    // positive overflow at entry 5
    for (int k = 0; k < 9; k++) mat[k] = pos(5);
    mat[5] = pos(15'h4000);
    run(9, 0);
    check(seen_ok == 0, "R3 positive 0x4000 rejected", longint'(seen_ok), 0);
    check(coef == held, "R7 coef held on reject", longint'(coef[63:0]), longint'(held[63:0]));

    // negative zero at entry 3
    for (int k = 0; k < 9; k++) mat[k] = pos(7);
    mat[3] = neg(0) | 64'h1234;
    run(9, 0);
    check(seen_ok == 0, "R3 negative zero rejected", longint'(seen_ok), 0);
    check(coef == held, "R7 coef held", longint'(coef[63:0]), longint'(held[63:0]));

    // bad on last entry
    for (int k = 0; k < 9; k++) mat[k] = pos(7);
    mat[8] = neg(15'h4001);
    run(9, 0);
    check(seen_ok == 0, "R3 bad last entry", longint'(seen_ok), 0);

    // upper garbage dropped
    for (int k = 0; k < 9; k++) mat[k] = pos(k);
    mat[4] = 64'h7fff_fff8_0000_0000 | pos(12'h123);
    mat[6] = 64'hffff_fff8_0000_0000 | pos(12'h010);
    run(9, 0);
    check(seen_ok == 1, "R5 garbage matrix ok", longint'(seen_ok), 1);
    check(slot(4) == 15'h0123, "R5 upper bits dropped", longint'(slot(4)), 15'h0123);
    check(slot(6) == 15'h7ff0, "R5 neg upper bits dropped", longint'(slot(6)), 15'h7ff0);
    held = coef;

    // short and long matrices
    for (int k = 0; k < 12; k++) mat[k] = pos(100 + k);
    run(8, 0);
    check(seen_ok == 0, "R9 eight entries rejected", longint'(seen_ok), 0);
    check(coef == held, "R9 coef held short", longint'(coef[63:0]), longint'(held[63:0]));
    run(10, 0);
    check(seen_ok == 0, "R9 ten entries rejected", longint'(seen_ok), 0);
    check(coef == held, "R9 coef held long", longint'(coef[63:0]), longint'(held[63:0]));

    // fresh start after rejects, with idle gaps
    for (int k = 0; k < 9; k++) mat[k] = neg(k + 1);
    run(9, 1);
    check(seen_ok == 1, "R10 fresh matrix after reject", longint'(seen_ok), 1);
    for (int k = 0; k < 9; k++)
      check(slot(k) == 15'(32768 - (k + 1)), "R8 gapped slot", longint'(slot(k)), 32768 - (k + 1));

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad_cnt++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end
endmodule